// File: doc/BRIEF.md
# 64-bit Compare-Match Timer

This block is a memory-mapped timer peripheral. A free-running 64-bit up-counter advances through an 8-bit clock prescaler. A 64-bit compare value is checked against the counter every cycle. When the counter reaches or passes the compare value, a sticky event flag is set, and that flag can be routed to an interrupt line. An auto-increment mode adds a programmable step to the compare value after every match, so the block produces periodic events without software reloading the compare value.

Software uses a 32-bit register port that has an address, write data, a write strobe, a read strobe and registered read data. The counter, the compare value and the step are all visible as 32-bit words. To move the compare point without a false event, software clears the compare-enable bit, writes both compare halves, and then sets the bit again.

Top module: `gtmr_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The counter's low word is at offset 0x00 and its high word at 0x04. Both can be read and written, and a carry out of the low word increments the high word. While control bit 0 is clear, the counter holds its value.
- R3: With control bit 0 set and prescaler field P (control bits 15:8), the counter advances by one every P+1 clock edges. The prescale phase restarts at zero each time the timer is enabled.
- R4: The control register is at offset 0x08. Bit 0 runs the timer, bit 1 enables the comparator, bit 2 enables the interrupt, bit 3 enables auto-increment, and bits 15:8 hold the prescaler. All other bits read as zero.
- R5: The compare low word is at 0x10, the compare high word at 0x14 and the 32-bit step at 0x18. Each reads back what was written, and each takes effect in the cycle after the write.
- R6: With control bit 1 set, the event flag is set on the clock edge that follows the first cycle in which counter >= compare (64-bit unsigned). It is not set again while that condition stays true. With bit 1 clear, no event is raised.
- R7: The status register at 0x0C holds the event flag in bit 0. Writing 1 to bit 0 clears the flag. Writing 0 leaves it unchanged. If a new event arrives in the same cycle as a clear, the event wins.
- R8: `irq` equals the event flag ANDed with control bit 2.
- R9: With control bits 1 and 3 set, each compare event adds the step to the compare value, so the next event comes one step later.
- R10: Reads return data on the edge after `rdEn`, and offsets that are not mapped read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte offset of the register |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Registered read data |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 32-bit data word and an 8-bit prescaler. It sweeps prescaler values 0 to 5 against run lengths of 0 to 12 edges, which covers every phase of the prescale divider and every partial period at those settings. Compare events are timed to the exact edge, including the edge-only firing rule, the masking of `irq`, a compare update made while the comparator is off, and two consecutive auto-increment periods. The counter is preloaded to 0xFFFFFFFF so that the carry from the low word into the high word is also exercised.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int OFF_CNT_LO = 'h00;
  localparam int OFF_CNT_HI = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_STATUS = 'h0C;
  localparam int OFF_CMP_LO = 'h10;
  localparam int OFF_CMP_HI = 'h14;
  localparam int OFF_STEP   = 'h18;

  localparam int BIT_RUN    = 0;
  localparam int BIT_CMP    = 1;
  localparam int BIT_IRQ    = 2;
  localparam int BIT_AUTO   = 3;
  localparam int PRESC_LSB  = 8;

  // Strobes and modes handed from the register control to the datapath.
  typedef struct packed {
    logic wrCntLo;
    logic wrCntHi;
    logic wrCmpLo;
    logic wrCmpHi;
    logic wrStep;
    logic timerEn;
    logic cmpEn;
    logic autoEn;
  } strobe_t;
endpackage

// File: rtl/gtmr_dp.sv
module gtmr_dp
  import gtmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PRESC_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [PRESC_W-1:0]  presc,
  output logic [2*DATA_W-1:0] count,
  output logic [2*DATA_W-1:0] cmpVal,
  output logic [DATA_W-1:0]   stepVal,
  output logic                hitEvt
);
  localparam int CNT_W = 2 * DATA_W;

  logic [PRESC_W-1:0] prescCnt;
  logic               tick;
  logic               cond;
  logic               condPrev;
  logic [CNT_W-1:0]   countNext;
  logic [CNT_W-1:0]   cmpNext;

  assign tick   = strb.timerEn && (prescCnt == presc);
  assign cond   = strb.cmpEn && (count >= cmpVal);
  assign hitEvt = cond && !condPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              prescCnt <= '0;
    else if (!strb.timerEn) prescCnt <= '0;
    else if (tick)          prescCnt <= '0;
    else                    prescCnt <= prescCnt + 1'b1;
  end

  // Software writes take priority over the tick in the same cycle.
  always_comb begin
    countNext = tick ? count + 1'b1 : count;
    if (strb.wrCntLo) countNext[DATA_W-1:0]     = wrData;
    if (strb.wrCntHi) countNext[CNT_W-1:DATA_W] = wrData;
  end

  // Software writes take priority over the auto-increment step.
  always_comb begin
    cmpNext = (hitEvt && strb.autoEn) ? cmpVal + CNT_W'(stepVal) : cmpVal;
    if (strb.wrCmpLo) cmpNext[DATA_W-1:0]     = wrData;
    if (strb.wrCmpHi) cmpNext[CNT_W-1:DATA_W] = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      cmpVal   <= '0;
      stepVal  <= '0;
      condPrev <= 1'b0;
    end else begin
      count    <= countNext;
      cmpVal   <= cmpNext;
      condPrev <= cond;
      if (strb.wrStep) stepVal <= wrData;
    end
  end
endmodule

// File: rtl/gtmr_ctrl.sv
module gtmr_ctrl
  import gtmr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int PRESC_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                rdEn,
  input  logic [2*DATA_W-1:0] count,
  input  logic [2*DATA_W-1:0] cmpVal,
  input  logic [DATA_W-1:0]   stepVal,
  input  logic                hitEvt,
  output logic [DATA_W-1:0]   rdData,
  output strobe_t             strb,
  output logic [PRESC_W-1:0]  presc,
  output logic                irqEn,
  output logic                flag,
  output logic                irq
);
  logic runBit, cmpBit, autoBit;
  logic selCtrl, selStatus;
  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] rdNext;

  assign selCtrl   = wrEn && (addr == ADDR_W'(OFF_CTRL));
  assign selStatus = wrEn && (addr == ADDR_W'(OFF_STATUS));

  always_comb begin
    strb         = '0;
    strb.wrCntLo = wrEn && (addr == ADDR_W'(OFF_CNT_LO));
    strb.wrCntHi = wrEn && (addr == ADDR_W'(OFF_CNT_HI));
    strb.wrCmpLo = wrEn && (addr == ADDR_W'(OFF_CMP_LO));
    strb.wrCmpHi = wrEn && (addr == ADDR_W'(OFF_CMP_HI));
    strb.wrStep  = wrEn && (addr == ADDR_W'(OFF_STEP));
    strb.timerEn = runBit;
    strb.cmpEn   = cmpBit;
    strb.autoEn  = autoBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      cmpBit  <= 1'b0;
      irqEn   <= 1'b0;
      autoBit <= 1'b0;
      presc   <= '0;
    end else if (selCtrl) begin
      runBit  <= wrData[BIT_RUN];
      cmpBit  <= wrData[BIT_CMP];
      irqEn   <= wrData[BIT_IRQ];
      autoBit <= wrData[BIT_AUTO];
      presc   <= wrData[PRESC_LSB +: PRESC_W];
    end
  end

  // A new event wins over a clear arriving in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          flag <= 1'b0;
    else if (hitEvt)                    flag <= 1'b1;
    else if (selStatus && wrData[0])    flag <= 1'b0;
  end

  assign irq = flag && irqEn;

  always_comb begin
    ctrlWord = '0;
    ctrlWord[BIT_RUN]  = runBit;
    ctrlWord[BIT_CMP]  = cmpBit;
    ctrlWord[BIT_IRQ]  = irqEn;
    ctrlWord[BIT_AUTO] = autoBit;
    ctrlWord[PRESC_LSB +: PRESC_W] = presc;
  end

  always_comb begin
    case (addr)
      ADDR_W'(OFF_CNT_LO): rdNext = count[DATA_W-1:0];
      ADDR_W'(OFF_CNT_HI): rdNext = count[2*DATA_W-1:DATA_W];
      ADDR_W'(OFF_CTRL):   rdNext = ctrlWord;
      ADDR_W'(OFF_STATUS): rdNext = DATA_W'(flag);
      ADDR_W'(OFF_CMP_LO): rdNext = cmpVal[DATA_W-1:0];
      ADDR_W'(OFF_CMP_HI): rdNext = cmpVal[2*DATA_W-1:DATA_W];
      ADDR_W'(OFF_STEP):   rdNext = stepVal;
      default:             rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
  import gtmr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int PRESC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  strobe_t             strb;
  logic [PRESC_W-1:0]  presc;
  logic [2*DATA_W-1:0] count;
  logic [2*DATA_W-1:0] cmpVal;
  logic [DATA_W-1:0]   stepVal;
  logic                hitEvt;
  logic                irqEn;
  logic                flag;

  gtmr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRESC_W(PRESC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .count(count), .cmpVal(cmpVal), .stepVal(stepVal),
    .hitEvt(hitEvt), .rdData(rdData), .strb(strb), .presc(presc),
    .irqEn(irqEn), .flag(flag), .irq(irq)
  );

  gtmr_dp #(.DATA_W(DATA_W), .PRESC_W(PRESC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .presc(presc),
    .count(count), .cmpVal(cmpVal), .stepVal(stepVal), .hitEvt(hitEvt)
  );
endmodule

// File: rtl/gtmr_chk.sv
module gtmr_chk
  import gtmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   addr,
  input logic                wrEn,
  input logic [DATA_W-1:0]   wrData,
  input strobe_t             strb,
  input logic [2*DATA_W-1:0] count,
  input logic [2*DATA_W-1:0] cmpVal,
  input logic [DATA_W-1:0]   stepVal,
  input logic                hitEvt,
  input logic                irqEn,
  input logic                flag,
  input logic                irq
);
  localparam int CNT_W = 2 * DATA_W;

  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.timerEn && !strb.wrCntLo && !strb.wrCntHi) |=> $stable(count));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.timerEn && !strb.wrCntLo && !strb.wrCntHi)
      |=> (count == $past(count) || count == $past(count) + 1'b1));

  a_r6_needs_comparator: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(strb.cmpEn));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFF_STATUS) && wrData[0] && !hitEvt) |=> !flag);

  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flag && irqEn));

  a_r9_step_added: assert property (@(posedge clk) disable iff (!rstN)
    (hitEvt && strb.autoEn && !strb.wrCmpLo && !strb.wrCmpHi)
      |=> cmpVal == $past(cmpVal) + CNT_W'($past(stepVal)));
endmodule

bind gtmr_top gtmr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .strb(strb), .count(count), .cmpVal(cmpVal), .stepVal(stepVal),
  .hitEvt(hitEvt), .irqEn(irqEn), .flag(flag), .irq(irq)
);

// File: tb/sim_gtmr_top.sv
`timescale 1ns/1ps
module sim_gtmr_top;
  localparam logic [7:0] A_CLO = 8'h00, A_CHI = 8'h04, A_CTL = 8'h08,
                         A_STS = 8'h0C, A_KLO = 8'h10, A_KHI = 8'h14,
                         A_STP = 8'h18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        irq;
  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gtmr_top u0 (.clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
               .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .irq(irq));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values
    check("R1 irq", irq, 0);
    foreach (v[i]) if (i < 7) begin
      rd(8'(i * 4), v);
      check("R1 reg", v, 0);
    end

    // R4: control field readback
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, v); check("R4 ctrl", v, 32'h0000_FF0F);
    wr(A_CTL, 0); wr(A_STS, 1);
    rd(A_STS, v); check("R7 cleared", v, 0);

    // R5: compare and step readback
    wr(A_KLO, 32'hA5A5_1234); wr(A_KHI, 32'h0F0F_8765); wr(A_STP, 32'h1357_9BDF);
    rd(A_KLO, v); check("R5 cmp lo", v, 32'hA5A5_1234);
    rd(A_KHI, v); check("R5 cmp hi", v, 32'h0F0F_8765);
    rd(A_STP, v); check("R5 step", v, 32'h1357_9BDF);

    // R10: unmapped offsets
    rd(8'h1C, v); check("R10 0x1C", v, 0);
    rd(8'h20, v); check("R10 0x20", v, 0);
    rd(8'hFC, v); check("R10 0xFC", v, 0);

    // R2: halves writable, hold while stopped, carry
    wr(A_CHI, 32'hDEAD_BEEF); idle(3);
    rd(A_CHI, v); check("R2 hi write/hold", v, 32'hDEAD_BEEF);
    wr(A_CLO, 32'hFFFF_FFFF); wr(A_CHI, 0);
    wr(A_CTL, 1); wr(A_CTL, 0);
    rd(A_CLO, v); check("R2 carry lo", v, 0);
    rd(A_CHI, v); check("R2 carry hi", v, 1);

    // R3: prescaler sweep
    for (int p = 0; p < 6; p++) begin
      for (int n = 0; n < 13; n++) begin
        wr(A_CTL, 0); wr(A_CLO, 0); wr(A_CHI, 0);
        wr(A_CTL, (p << 8) | 1);
        idle(n);
        wr(A_CTL, 0);
        rd(A_CLO, v); check($sformatf("R3 p=%0d n=%0d", p, n), v, (n + 1) / (p + 1));
      end
    end

    // R6/R8: compare timing
    wr(A_CTL, 0); wr(A_CLO, 0); wr(A_CHI, 0); wr(A_KLO, 10); wr(A_KHI, 0);
    wr(A_CTL, 32'h7);
    idle(9);  check("R6 before match", irq, 0);
    idle(1);  check("R6 match cycle", irq, 0);
    idle(1);  check("R6 event edge", irq, 1);
    // R7: write-one-to-clear, no re-raise
    wr(A_STS, 0); check("R7 zero write", irq, 1);
    wr(A_STS, 1); idle(3); check("R7 no re-raise", irq, 0);
    rd(A_STS, v); check("R7 status", v, 0);
    // R8: masking
    wr(A_CTL, 1); wr(A_CTL, 3); idle(1);
    check("R8 masked", irq, 0);
    rd(A_STS, v); check("R8 flag set", v, 1);
    wr(A_CTL, 7); check("R8 unmasked", irq, 1);
    // R6: update while comparator off raises nothing
    wr(A_CTL, 1); wr(A_STS, 1);
    wr(A_KLO, 5); idle(2);
    rd(A_STS, v); check("R6 cmp off", v, 0);
    wr(A_KHI, 1); wr(A_CTL, 7); idle(2);
    rd(A_STS, v); check("R6 far compare", v, 0);
    check("R6 irq quiet", irq, 0);

    // R9: auto-increment, two periods
    wr(A_CTL, 0); wr(A_STS, 1); wr(A_CLO, 0); wr(A_CHI, 0);
    wr(A_KLO, 4); wr(A_KHI, 0); wr(A_STP, 6);
    wr(A_CTL, 32'hB); idle(5); wr(A_CTL, 0);
    rd(A_KLO, v); check("R9 first step", v, 10);
    rd(A_STS, v); check("R9 first event", v, 1);
    wr(A_STS, 1); wr(A_CLO, 9);
    wr(A_CTL, 32'hB); idle(2); wr(A_CTL, 0);
    rd(A_KLO, v); check("R9 second step", v, 16);
    rd(A_STS, v); check("R9 second event", v, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule